// File: doc/BRIEF.md
# Synchronous serial port controller

This block is a register-mapped SPI master. Software writes words into an eight-entry transmit queue and reads the words that come back from an eight-entry receive queue. Both queues sit behind one data address, so a write to that address loads the transmit queue and a read from it takes one word from the receive queue. Each word that leaves the transmit queue becomes one frame on the serial pins. During that frame the device select line is held low and the bit clock toggles twice for every bit. At the same time the word sampled from the input pin is collected and placed in the receive queue.

The bit clock comes from two dividers in series. The first divides by an even prescale value. The second divides by one plus an eight-bit rate value, which sits in the upper byte of the first control word. The low bits of that control word give the frame length as the number of bits minus one. Two further bits give the idle level of the clock and the edge on which data is sampled, so all four SPI modes are available. A status word reports whether each queue is empty or full, and whether the port is busy.

The register interface is a plain single-cycle bus. A write takes effect on the clock edge on which the write strobe is high. Read data follows the address without delay, and a read of the data address takes one word from the receive queue on that same edge.

Top module: `ssp_master`

## Requirements
- R1: After reset the status word reads 0x0003, the device select output is high and the bit clock output is low.
- R2: The registers sit at these byte offsets: control 0 at 0x00, control 1 at 0x04, data at 0x08, status at 0x0C and prescale at 0x10. Control 0 reads back all 16 bits. Control 1 reads back only bit 1. Prescale reads back bits 7:0, and bit 0 always reads as 0.
- R3: Status bit positions: bit 0 is transmit queue empty, bit 1 is transmit queue not full, bit 2 is receive queue not empty, bit 3 is receive queue full and bit 4 is busy. All other bits read 0.
- R4: One half-period of the bit clock lasts (P/2)·(1+R) input clock cycles. P is the even prescale value and R is control 0 bits 15:8. A prescale value below 2 acts as 2.
- R5: Control 0 bits 3:0 hold the frame length minus one. Values 3 to 15 select 4 to 16 bits, and smaller values select 4 bits. Data is sent most significant bit first. Only the low bits of a written word are sent. A received word is right-justified and zero-extended on readback.
- R6: Control 0 bit 6 sets the idle level of the bit clock. Control 0 bit 7 selects the sampling edge. With bit 7 clear, data is sampled on the first edge of each bit and changes on the second edge. With bit 7 set, data changes on the first edge and is sampled on the second.
- R7: Control 1 bit 1 enables the port. While this bit is clear no frame starts and no word leaves the transmit queue. Clearing it during a frame abandons that frame: device select goes high within two cycles and no received word is stored.
- R8: The transmit queue holds 8 words. A write to the data address while the transmit queue is full is dropped.
- R9: The receive queue holds 8 words. A word received while the receive queue is full is discarded. A read of the data address while the receive queue is empty returns 0 and changes nothing.
- R10: Busy is set while a frame is in progress or while the transmit queue is not empty.
- R11: Each frame holds device select low for exactly twice as many clock edges as it has bits. Device select returns high between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at the data address) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Device select, low during a frame |

## Verification
The bench builds the block with its default parameters: 16-bit data, queues eight deep and a five-bit address. With these values the bench can reach every frame length from 4 to 16 bits, and it can fill both queues with ten writes. The full eight-bit prescale and rate fields are also available, so the bench checks odd, minimum and larger divider settings. A slave model in the bench follows the configured mode on its own. It returns a different word for each frame, which shows whether the kept or the dropped words reached the receive queue.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   // register byte offsets
   localparam int unsigned OFS_CTRL0 = 0;
   localparam int unsigned OFS_CTRL1 = 4;
   localparam int unsigned OFS_DATA  = 8;
   localparam int unsigned OFS_STAT  = 12;
   localparam int unsigned OFS_PRE   = 16;

   // status bit positions
   localparam int unsigned ST_TX_EMPTY = 0;
   localparam int unsigned ST_TX_ROOM  = 1;
   localparam int unsigned ST_RX_AVAIL = 2;
   localparam int unsigned ST_RX_FULL  = 3;
   localparam int unsigned ST_BUSY     = 4;

   // control field positions
   localparam int unsigned C0_POL  = 6;
   localparam int unsigned C0_PHA  = 7;
   localparam int unsigned C0_RATE = 8;
   localparam int unsigned C1_EN   = 1;

   localparam int unsigned REG_W  = 16;
   localparam int unsigned RATE_W = 8;
   localparam int unsigned PRE_W  = 8;

   typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ssp_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   // R9: a push into a full queue without a pop leaves it unchanged
   assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == $past(cnt)));

   assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
   parameter int unsigned HALF_W = 7,
   parameter int unsigned RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half_div,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int unsigned GAP_W = HALF_W + RATE_W + 1;

   logic [HALF_W-1:0] half_eff, pre_cnt;
   logic [RATE_W-1:0] rate_cnt;
   logic              pre_wrap;

   assign half_eff = (half_div == '0) ? HALF_W'(1) : half_div;
   assign pre_wrap = (pre_cnt == half_eff - 1'b1);
   assign tick     = run && pre_wrap && (rate_cnt == rate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt  <= '0;
         rate_cnt <= '0;
      end else if (!run) begin
         pre_cnt  <= '0;
         rate_cnt <= '0;
      end else if (pre_wrap) begin
         pre_cnt  <= '0;
         rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + 1'b1;
      end else begin
         pre_cnt <= pre_cnt + 1'b1;
      end
   end

   // independent cycle counter for the half-period check
   logic [GAP_W-1:0] gap;
   logic [GAP_W-1:0] gap_exp;
   assign gap_exp = GAP_W'(half_eff) * (GAP_W'(rate) + 1'b1) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           gap <= '0;
      else if (!run || tick) gap <= '0;
      else                  gap <= gap + 1'b1;
   end

   assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (gap == gap_exp));
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift
   import ssp_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   pol,
   input  logic                   pha,
   input  logic [$clog2(DW)-1:0]  nbm1,
   input  logic                   tick,
   input  logic                   tx_avail,
   input  logic [DW-1:0]          tx_word,
   input  logic                   miso,
   output logic                   tx_pop,
   output logic                   rx_push,
   output logic [DW-1:0]          rx_word,
   output logic                   active,
   output logic                   sclk,
   output logic                   mosi,
   output logic                   cs_n
);
   localparam int unsigned NB_W = $clog2(DW);
   localparam int unsigned EW   = NB_W + 2;

   sh_state_e     state;
   logic [DW-1:0] tx_sr, rx_sr;
   logic [EW-1:0] edge_q, last_q;
   logic          f_pha, f_pol, sclk_q, csn_q;
   logic          sample_e, fin;

   assign tx_pop   = (state == SH_IDLE) && en && tx_avail;
   assign sample_e = (edge_q[0] == f_pha);
   assign fin      = (state == SH_RUN) && en && tick && (edge_q == last_q);
   assign rx_push  = fin;
   assign rx_word  = f_pha ? {rx_sr[DW-2:0], miso} : rx_sr;
   assign active   = (state == SH_RUN);
   assign sclk     = sclk_q;
   assign mosi     = tx_sr[DW-1];
   assign cs_n     = csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SH_IDLE;
         tx_sr  <= '0;
         rx_sr  <= '0;
         edge_q <= '0;
         last_q <= '0;
         f_pha  <= 1'b0;
         f_pol  <= 1'b0;
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
      end else if (state == SH_IDLE) begin
         sclk_q <= pol;
         csn_q  <= 1'b1;
         if (tx_pop) begin
            state  <= SH_RUN;
            csn_q  <= 1'b0;
            tx_sr  <= tx_word << (NB_W'(DW - 1) - nbm1);
            rx_sr  <= '0;
            edge_q <= '0;
            last_q <= EW'({nbm1, 1'b1});
            f_pha  <= pha;
            f_pol  <= pol;
         end
      end else if (!en) begin
         state  <= SH_IDLE;
         csn_q  <= 1'b1;
         sclk_q <= f_pol;
      end else if (tick) begin
         sclk_q <= ~sclk_q;
         edge_q <= edge_q + 1'b1;
         if (sample_e)
            rx_sr <= {rx_sr[DW-2:0], miso};
         else if (edge_q != '0)
            tx_sr <= {tx_sr[DW-2:0], 1'b0};
         if (fin) begin
            state <= SH_IDLE;
            csn_q <= 1'b1;
         end
      end
   end

   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cs_n);

   assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (sclk == f_pol));

   assert_frame_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> cs_n);

   assert_frame_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> !cs_n);
endmodule

// File: rtl/ssp_master.sv
module ssp_master
   import ssp_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned ADDR_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);
   localparam int unsigned NB_W = $clog2(DW);

   generate
      if (DW < 4 || DW > 16) begin : g_bad_dw
         $error("ssp_master: DW must lie in 4..16");
      end
      if (ADDR_W < 5) begin : g_bad_aw
         $error("ssp_master: ADDR_W must be at least 5");
      end
   endgenerate

   logic [REG_W-1:0] ctrl0_q;
   logic             en_q;
   logic [PRE_W-1:0] pre_q;

   logic sel_c0, sel_c1, sel_dat, sel_st, sel_pre;
   assign sel_c0  = (bus_addr == ADDR_W'(OFS_CTRL0));
   assign sel_c1  = (bus_addr == ADDR_W'(OFS_CTRL1));
   assign sel_dat = (bus_addr == ADDR_W'(OFS_DATA));
   assign sel_st  = (bus_addr == ADDR_W'(OFS_STAT));
   assign sel_pre = (bus_addr == ADDR_W'(OFS_PRE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl0_q <= '0;
         en_q    <= 1'b0;
         pre_q   <= '0;
      end else if (bus_wr) begin
         if (sel_c0)  ctrl0_q <= bus_wdata;
         if (sel_c1)  en_q    <= bus_wdata[C1_EN];
         if (sel_pre) pre_q   <= {bus_wdata[PRE_W-1:1], 1'b0};
      end
   end

   // frame length field, clamped to the supported range
   logic [3:0]      dss;
   logic [NB_W-1:0] nbm1;
   assign dss = ctrl0_q[3:0];
   generate
      if (DW == 16) begin : g_full_dss
         assign nbm1 = (dss < 4'd3) ? NB_W'(3) : NB_W'(dss);
      end else begin : g_clamp_dss
         assign nbm1 = (dss < 4'd3)      ? NB_W'(3) :
                       (dss > 4'(DW-1))  ? NB_W'(DW - 1) : NB_W'(dss);
      end
   endgenerate

   // queues
   logic          tx_push, tx_pop, tx_empty, tx_full;
   logic          rx_push, rx_pop, rx_empty, rx_full;
   logic [DW-1:0] tx_head, rx_head, rx_word;

   assign tx_push = bus_wr && sel_dat;
   assign rx_pop  = bus_rd && sel_dat;

   ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[DW-1:0]),
      .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full));

   ssp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
      .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full));

   // bit clock divider and shift engine
   logic tick, active;

   ssp_clkgen #(.HALF_W(PRE_W - 1), .RATE_W(RATE_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(active),
      .half_div(pre_q[PRE_W-1:1]),
      .rate(ctrl0_q[C0_RATE +: RATE_W]),
      .tick(tick));

   ssp_shift #(.DW(DW)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en_q),
      .pol(ctrl0_q[C0_POL]), .pha(ctrl0_q[C0_PHA]), .nbm1(nbm1),
      .tick(tick), .tx_avail(!tx_empty), .tx_word(tx_head), .miso(miso),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
      .active(active), .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

   // register readback
   logic [REG_W-1:0] status;
   always_comb begin
      status = '0;
      status[ST_TX_EMPTY] = tx_empty;
      status[ST_TX_ROOM]  = !tx_full;
      status[ST_RX_AVAIL] = !rx_empty;
      status[ST_RX_FULL]  = rx_full;
      status[ST_BUSY]     = active || !tx_empty;
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_c0)  bus_rdata = ctrl0_q;
      if (sel_c1)  bus_rdata[C1_EN] = en_q;
      if (sel_dat) bus_rdata = rx_empty ? '0 : REG_W'(rx_head);
      if (sel_st)  bus_rdata = status;
      if (sel_pre) bus_rdata = REG_W'(pre_q);
   end

   // R10: a frame only starts with the port enabled and the status busy
   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (status[ST_BUSY] && en_q));
endmodule

// File: tb/tb_ssp_master.sv
`timescale 1ns/1ps
module tb_ssp_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        sclk, mosi, cs_n;
   logic        miso = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ssp_master dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

   // ---------------- slave model ----------------
   int          cfg_n = 8;
   logic        cfg_pol = 1'b0;
   logic        cfg_pha = 1'b0;
   logic [15:0] slave_base = '0;
   int          frame_idx = 0;
   int          frame_n = 8;
   logic        frame_pha = 1'b0;
   logic        frame_pol = 1'b0;
   int          slv_edges = 100;
   int          bitidx = 0;
   int          bad_frames = 0;
   logic [15:0] resp = '0, cap = '0, last_cap = '0;
   realtime     last_t = 0.0, gap_t = 0.0;

   function automatic logic [15:0] mask16(int n);
      logic [16:0] m;
      m = (17'd1 << n) - 17'd1;
      return m[15:0];
   endfunction

   always @(negedge cs_n) begin
      if (frame_idx > 0 && slv_edges != 2 * frame_n) bad_frames++;
      frame_n   = cfg_n;
      frame_pha = cfg_pha;
      frame_pol = cfg_pol;
      slv_edges = 0;
      resp      = (slave_base + 16'(frame_idx)) & mask16(cfg_n);
      frame_idx++;
      cap       = '0;
      bitidx    = cfg_n - 1;
      if (!cfg_pha) miso = resp[bitidx];
   end

   always @(sclk) begin
      if (slv_edges < 2 * frame_n) begin
         if (slv_edges == 1) gap_t = $realtime - last_t;
         last_t = $realtime;
         if (!frame_pha) begin
            if (sclk != frame_pol) cap = {cap[14:0], mosi};
            else if (bitidx > 0) begin
               bitidx--;
               miso = resp[bitidx];
            end
         end else begin
            if (sclk != frame_pol) miso = resp[bitidx];
            else begin
               cap = {cap[14:0], mosi};
               if (bitidx > 0) bitidx--;
            end
         end
         slv_edges++;
         if (slv_edges == 2 * frame_n) last_cap = cap;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(int a, logic [15:0] d);
      @(negedge clk);
      bus_addr  = 5'(a);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(int a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = 5'(a);
      bus_rd   = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      for (int i = 0; i < 5000; i++) begin
         bus_read(12, s);
         if (!s[4]) break;
      end
   endtask

   task automatic set_cfg(int n, logic pol, logic pha, logic [7:0] pre,
                          logic [7:0] rate, logic en);
      cfg_n   = n;
      cfg_pol = pol;
      cfg_pha = pha;
      bus_write(0, {rate, pha, pol, 2'b00, 4'(n - 1)});
      bus_write(16, {8'h00, pre});
      bus_write(4, en ? 16'h0002 : 16'h0000);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      logic [15:0] r;
      bus_read(12, r);
      chk("R1 reset status", r, 16'h0003);
      chk("R1 reset cs_n", {15'b0, cs_n}, 16'h0001);
      chk("R1 reset sclk", {15'b0, sclk}, 16'h0000);
      bus_read(8, r);
      chk("R9 empty read", r, 16'h0000);
   endtask

   task automatic t_regs();
      logic [15:0] r;
      bus_write(0, 16'hA5C7);
      bus_read(0, r);
      chk("R2 ctrl0 readback", r, 16'hA5C7);
      bus_write(4, 16'hFFFF);
      bus_read(4, r);
      chk("R2 ctrl1 readback", r, 16'h0002);
      bus_write(4, 16'h0000);
      bus_write(16, 16'hFF37);
      bus_read(16, r);
      chk("R2 prescale even", r, 16'h0036);
      bus_write(0, 16'h0007);
      bus_read(12, r);
      chk("R3 idle status", r, 16'h0003);
   endtask

   task automatic t_modes();
      for (int m = 0; m < 4; m++) begin
         logic [15:0] tx, r, exp;
         int fi;
         set_cfg(8, m[1], m[0], 8'd2, 8'd1, 1'b1);
         slave_base = 16'h003C + 16'(m);
         tx = 16'h00A5 ^ 16'(m * 17);
         fi = frame_idx;
         bus_write(8, tx);
         wait_idle();
         chk("R5 mode transmit", last_cap, tx & 16'h00FF);
         bus_read(8, r);
         exp = (slave_base + 16'(fi)) & 16'h00FF;
         chk("R6 mode receive", r, exp);
         chk("R6 idle level", {15'b0, sclk}, {15'b0, cfg_pol});
      end
   endtask

   task automatic t_sizes();
      logic [15:0] r;
      int fi;
      set_cfg(4, 1'b0, 1'b0, 8'd2, 8'd0, 1'b1);
      slave_base = 16'h1234;
      fi = frame_idx;
      bus_write(8, 16'hFFFB);
      wait_idle();
      chk("R5 4-bit transmit", last_cap, 16'h000B);
      bus_read(8, r);
      chk("R5 4-bit zero-extended", r, (16'h1234 + 16'(fi)) & 16'h000F);
      set_cfg(16, 1'b1, 1'b1, 8'd2, 8'd0, 1'b1);
      slave_base = 16'h8001;
      fi = frame_idx;
      bus_write(8, 16'hC3A5);
      wait_idle();
      chk("R5 16-bit transmit", last_cap, 16'hC3A5);
      bus_read(8, r);
      chk("R5 16-bit receive", r, 16'h8001 + 16'(fi));
      chk("R11 frame edge count", 16'(bad_frames), 16'h0000);
   endtask

   task automatic t_divider();
      logic [15:0] r;
      set_cfg(8, 1'b0, 1'b0, 8'd4, 8'd2, 1'b1);
      bus_write(8, 16'h0055);
      wait_idle();
      chk("R4 half period 4/2*3", 16'(int'(gap_t / 5.0)), 16'd6);
      bus_read(8, r);
      set_cfg(8, 1'b0, 1'b0, 8'd7, 8'd2, 1'b1);
      bus_read(16, r);
      chk("R2 odd prescale", r, 16'h0006);
      bus_write(8, 16'h0033);
      wait_idle();
      chk("R4 half period 6/2*3", 16'(int'(gap_t / 5.0)), 16'd9);
      bus_read(8, r);
      set_cfg(8, 1'b0, 1'b0, 8'd1, 8'd0, 1'b1);
      bus_write(8, 16'h0066);
      wait_idle();
      chk("R4 prescale below 2", 16'(int'(gap_t / 5.0)), 16'd1);
      bus_read(8, r);
   endtask

   task automatic t_fifo();
      logic [15:0] r;
      int fi0;
      set_cfg(8, 1'b0, 1'b0, 8'd2, 8'd0, 1'b0);
      slave_base = 16'h0040;
      fi0 = frame_idx;
      for (int i = 0; i < 10; i++) bus_write(8, 16'h0010 + 16'(i));
      repeat (4) @(negedge clk);
      bus_read(12, r);
      chk("R8 R10 full tx disabled status", r, 16'h0010);
      chk("R7 no frame while disabled", 16'(frame_idx - fi0), 16'd0);
      chk("R7 cs_n high while disabled", {15'b0, cs_n}, 16'h0001);
      bus_write(4, 16'h0002);
      wait_idle();
      chk("R8 frames from full queue", 16'(frame_idx - fi0), 16'd8);
      chk("R8 last kept word", last_cap, 16'h0017);
      bus_read(12, r);
      chk("R3 R9 rx full status", r, 16'h000F);
      bus_write(8, 16'h001A);
      bus_write(8, 16'h001B);
      wait_idle();
      chk("R8 extra frames", 16'(frame_idx - fi0), 16'd10);
      chk("R8 extra word sent", last_cap, 16'h001B);
      for (int i = 0; i < 8; i++) begin
         bus_read(8, r);
         chk("R9 kept receive order", r, (16'h0040 + 16'(fi0 + i)) & 16'h00FF);
      end
      bus_read(8, r);
      chk("R9 empty after drain", r, 16'h0000);
      bus_read(12, r);
      chk("R3 drained status", r, 16'h0003);
      chk("R11 frame edge count", 16'(bad_frames), 16'h0000);
   endtask

   task automatic t_abort();
      logic [15:0] r;
      set_cfg(8, 1'b0, 1'b0, 8'd20, 8'd0, 1'b1);
      bus_write(8, 16'h005A);
      for (int i = 0; i < 100 && cs_n; i++) @(negedge clk);
      chk("R11 cs_n low in frame", {15'b0, cs_n}, 16'h0000);
      repeat (25) @(negedge clk);
      bus_read(12, r);
      chk("R10 busy while shifting", r, 16'h0013);
      bus_write(4, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R7 abort raises cs_n", {15'b0, cs_n}, 16'h0001);
      bus_read(12, r);
      chk("R7 abort stores nothing", r, 16'h0003);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_modes();
      t_sizes();
      t_divider();
      t_fifo();
      t_abort();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule